// File: doc/BRIEF.md
# Most-significant-first minimum-weight signed-digit recoder

This block turns a two's complement word into a binary signed-digit word of the same width. The result has the same value and the fewest nonzero digits any signed-digit form of that value can have. Each output position holds one digit in {-1, 0, +1}, carried on two wires: a magnitude bit and a negative-sign bit. It is pure combinational logic with no clock, so a caller can place it in front of a shift-and-add multiplier or a coefficient store and register the digits wherever its own timing allows.

The recoding starts at the top bit and works down to bit 0. Each position looks at its own bit and the two bits below it, and a one-bit pass flag travels from each position to the one below. Positions that need bits below bit 0 read zeros. The output has minimum weight, but the non-adjacent property is not enforced, so two neighbouring digits can both be nonzero. The pass flag entering the top position is fixed at zero.

Top module: `msd_l2r_recoder`

## Requirements
- R1: For every input, the sum over i of digit_i * 2^i, taken modulo 2^WIDTH, equals the input word. Digit_i is +1 when mag[i]=1 and neg[i]=0, -1 when mag[i]=1 and neg[i]=1, and 0 when mag[i]=0.
- R2: The number of set bits in `dig_mag` equals the nonzero-digit count of the non-adjacent form of the input read as a signed WIDTH-bit value.
- R3: A zero digit is always encoded with both wires low, so `dig_neg` is never 1 where `dig_mag` is 0.
- R4: An all-zero input yields all-zero `dig_mag` and `dig_neg`.
- R5: At WIDTH=6 the input 6'b011101 (+29) yields `dig_mag` 6'b100011 and `dig_neg` 6'b000011, that is +32 -2 -1, with two adjacent nonzero digits.
- R6: The most negative input (only the top bit set) yields one digit, -1, at the top position.
- R7: An all-ones input (-1) yields one digit, -1, at position 0. The zero padding below bit 0 decides this result.
- R8: Alternating inputs collapse pairs of opposite Booth digits. At WIDTH=8, 8'h55 yields `dig_mag` 8'h55 with `dig_neg` 8'h00, and 8'hAA (-86) yields `dig_mag` 8'h56 with `dig_neg` 8'h56.
- R9: The outputs depend only on the current input, with no storage. A new input is reflected in the outputs in the same cycle it is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | WIDTH | Two's complement word to recode |
| dig_mag | output | WIDTH | Per-position digit magnitude, 1 for a nonzero digit |
| dig_neg | output | WIDTH | Per-position digit sign, 1 for -1, 0 for +1 or zero |

## Verification
The hardest case to reach is a long merge chain. Here the pass flag is set by an alternating pair, is consumed one position lower, and then is set again. Whether this chain ends correctly depends on the zero padding below bit 0. The value and weight properties are also only convincing when every input is covered. For these reasons, the stimulus applies every input word at both WIDTH=6 and WIDTH=8, and it adds directed alternating, all-ones and most-negative words with exact expected digit patterns. Each applied word is pushed as an expected item that a monitor compares half a cycle later.

// File: rtl/msd_pkg.sv
package msd_pkg;

  // Number of zero bits appended below bit 0 to fill the lowest windows.
  localparam int unsigned WIN_PAD = 2;

  // State carried from one position to the next lower one.
  typedef enum logic {
    FLAG_IDLE = 1'b0,
    FLAG_PASS = 1'b1
  } chain_flag_t;

endpackage

// File: rtl/msd_window_tap.sv
module msd_window_tap #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] tap_next,
  output logic [WIDTH-1:0] tap_third
);
  import msd_pkg::*;

  localparam int unsigned PADDED_W = WIDTH + WIN_PAD;

  logic [PADDED_W-1:0] padded;

  assign padded = {din, {WIN_PAD{1'b0}}};

  // Position i reads din[i-1] and din[i-2]; padded index i+WIN_PAD is din[i].
  for (genvar i = 0; i < WIDTH; i++) begin : g_tap
    assign tap_next[i]  = padded[i + WIN_PAD - 1];
    assign tap_third[i] = padded[i + WIN_PAD - 2];
  end

endmodule

// File: rtl/msd_digit_cell.sv
module msd_digit_cell
  import msd_pkg::*;
(
  input  logic        bit_own,
  input  logic        bit_next,
  input  logic        bit_third,
  input  chain_flag_t flag_i,
  output logic        mag_o,
  output logic        neg_o,
  output chain_flag_t flag_o
);

  logic        pair_differs;
  logic        mag_c;
  logic        neg_c;
  chain_flag_t flag_c;

  assign pair_differs = bit_own ^ bit_next;

  always_comb begin
    mag_c  = 1'b0;
    neg_c  = 1'b0;
    flag_c = FLAG_IDLE;
    if (flag_i == FLAG_PASS) begin
      // Consume the pending merge: the digit is nonzero on a bit change,
      // and its sign follows the inverse of this position's bit.
      mag_c = pair_differs;
      neg_c = pair_differs & ~bit_own;
    end else if (pair_differs) begin
      // A transition: emit here only if the one below is not a transition.
      flag_c = FLAG_PASS;
      mag_c  = ~(bit_next ^ bit_third);
      neg_c  = ~(bit_next ^ bit_third) & bit_own;
    end
  end

  assign mag_o  = mag_c;
  assign neg_o  = neg_c;
  assign flag_o = flag_c;

endmodule

// File: rtl/msd_l2r_recoder.sv
module msd_l2r_recoder #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dig_mag,
  output logic [WIDTH-1:0] dig_neg
);
  import msd_pkg::*;

  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] TOP_ONLY = {1'b1, {(WIDTH-1){1'b0}}};
  localparam logic [WIDTH-1:0] LSB_ONLY = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] tap_next;
  logic [WIDTH-1:0] tap_third;
  chain_flag_t      chain [WIDTH+1];

  msd_window_tap #(.WIDTH(WIDTH)) u_tap (
    .din       (din),
    .tap_next  (tap_next),
    .tap_third (tap_third)
  );

  // The flag entering the top position is always idle.
  assign chain[WIDTH] = FLAG_IDLE;

  for (genvar i = WIDTH - 1; i >= 0; i--) begin : g_cell
    msd_digit_cell u_cell (
      .bit_own   (din[i]),
      .bit_next  (tap_next[i]),
      .bit_third (tap_third[i]),
      .flag_i    (chain[i+1]),
      .mag_o     (dig_mag[i]),
      .neg_o     (dig_neg[i]),
      .flag_o    (chain[i])
    );
  end

  // Checks over the assembled digit vector.
  logic [WIDTH-1:0] pos_part;
  logic [WIDTH-1:0] neg_part;

  assign pos_part = dig_mag & ~dig_neg;
  assign neg_part = dig_mag & dig_neg;

  always_comb begin
    assert_value_match_R1: assert ((pos_part - neg_part) == din)
      else $error("R1 digit sum differs from input");
    assert_zero_in_R4: assert (din != '0 || (dig_mag == '0 && dig_neg == '0))
      else $error("R4 zero input gave nonzero digits");
    assert_most_negative_R6: assert (din != TOP_ONLY ||
                                     (dig_mag == TOP_ONLY && dig_neg == TOP_ONLY))
      else $error("R6 most negative input misrecoded");
    assert_all_ones_R7: assert (din != ALL_ONES ||
                                (dig_mag == LSB_ONLY && dig_neg == LSB_ONLY))
      else $error("R7 all-ones input misrecoded");
    // R7: a flag left pending below bit 0 means bit 0 itself began a run
    // and the padding closed it, so digit 0 is nonzero with the sign of bit 0.
    assert_tail_digit_R7: assert (chain[0] != FLAG_PASS ||
                                  (dig_mag[0] && (dig_neg[0] == din[0])))
      else $error("R7 pending flag at the tail without a tail digit");
  end

  // R2: a position that emits a digit while raising the flag leaves the
  // position below it with a zero digit.
  for (genvar i = 1; i < WIDTH; i++) begin : g_run_chk
    always_comb begin
      assert_run_end_zero_R2: assert (!(chain[i] == FLAG_PASS &&
                                        chain[i+1] == FLAG_IDLE &&
                                        dig_mag[i]) || !dig_mag[i-1])
        else $error("R2 nonzero digit right after an emitted run start");
    end
  end

endmodule

// File: tb/msd_l2r_recoder_tb.sv
module msd_l2r_recoder_tb;

  typedef struct {
    bit          narrow;     // 1: item for the 6-bit instance
    logic [7:0]  stim;
    bit          exact;      // 1: compare digit patterns exactly
    logic [7:0]  exp_mag;
    logic [7:0]  exp_neg;
    string       tag;
  } sb_item_t;

  logic clk;
  logic rst_n;
  logic [7:0] din8;
  logic [7:0] mag8;
  logic [7:0] neg8;
  logic [5:0] din6;
  logic [5:0] mag6;
  logic [5:0] neg6;

  int checks;
  int failures;
  bit finished;
  sb_item_t sb_q[$];

  initial clk = 1'b0;
  always #5 clk = ~clk;

  msd_l2r_recoder #(.WIDTH(8)) u_dut (
    .din (din8), .dig_mag (mag8), .dig_neg (neg8)
  );

  msd_l2r_recoder #(.WIDTH(6)) u_dut6 (
    .din (din6), .dig_mag (mag6), .dig_neg (neg6)
  );

  function automatic int signed_of(input logic [7:0] v, input int w);
    int u;
    u = int'(v) & ((1 << w) - 1);
    if (v[w-1]) u = u - (1 << w);
    return u;
  endfunction

  function automatic int digit_sum(input logic [7:0] m, input logic [7:0] n, input int w);
    int acc;
    acc = 0;
    for (int i = 0; i < w; i++)
      if (m[i]) acc = n[i] ? acc - (1 << i) : acc + (1 << i);
    return acc;
  endfunction

  function automatic int naf_weight(input int x);
    int v;
    int wt;
    v = x;
    wt = 0;
    while (v != 0) begin
      if ((v & 1) != 0) begin
        if ((v & 3) == 1) v = v - 1;
        else v = v + 1;
        wt++;
      end
      v = v / 2;
    end
    return wt;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Driver: applies a word and queues what the monitor must see.
  task automatic drive(input bit narrow, input logic [7:0] v, input bit exact,
                       input logic [7:0] em, input logic [7:0] en, input string tag);
    sb_item_t it;
    @(posedge clk);
    #1;
    if (narrow) din6 = v[5:0];
    else din8 = v;
    it.narrow = narrow; it.stim = v; it.exact = exact;
    it.exp_mag = em; it.exp_neg = en; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // Monitor: half a cycle after each drive, compares the outputs.
  always @(negedge clk) begin
    if (rst_n && sb_q.size() > 0) begin
      sb_item_t it;
      int w;
      int sv;
      logic [7:0] m;
      logic [7:0] n;
      it = sb_q.pop_front();
      w = it.narrow ? 6 : 8;
      m = it.narrow ? {2'b00, mag6} : mag8;
      n = it.narrow ? {2'b00, neg6} : neg8;
      sv = signed_of(it.stim, w);
      // R1 and R9: value seen in the same cycle as the applied word
      check(digit_sum(m, n, w) == sv, "R1", "digit sum", digit_sum(m, n, w), sv);
      // R2: minimum weight
      check($countones(m) == naf_weight(sv), "R2", "weight",
            $countones(m), naf_weight(sv));
      // R3: zero digits carry no sign
      check((n & ~m) == 8'h00, "R3", "sign on zero digit", int'(n & ~m), 0);
      if (it.exact) begin
        check(m == it.exp_mag, it.tag, "magnitudes", int'(m), int'(it.exp_mag));
        check(n == it.exp_neg, it.tag, "signs", int'(n), int'(it.exp_neg));
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    checks = 0;
    failures = 0;
    finished = 1'b0;
    rst_n = 1'b0;
    din8 = 8'h00;
    din6 = 6'h00;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    // R4: idle input straight after reset
    drive(1'b0, 8'h00, 1'b1, 8'h00, 8'h00, "R4");
    // R5: non-canonical example at six digits
    drive(1'b1, 8'h1D, 1'b1, 8'h23, 8'h03, "R5");
    // R6: most negative word
    drive(1'b0, 8'h80, 1'b1, 8'h80, 8'h80, "R6");
    drive(1'b1, 8'h20, 1'b1, 8'h20, 8'h20, "R6");
    // R7: all ones
    drive(1'b0, 8'hFF, 1'b1, 8'h01, 8'h01, "R7");
    drive(1'b1, 8'h3F, 1'b1, 8'h01, 8'h01, "R7");
    // R8: alternating words
    drive(1'b0, 8'h55, 1'b1, 8'h55, 8'h00, "R8");
    drive(1'b0, 8'hAA, 1'b1, 8'h56, 8'h56, "R8");
    // R9: back-to-back changes, each checked in its own cycle
    drive(1'b0, 8'h00, 1'b1, 8'h00, 8'h00, "R9");
    drive(1'b0, 8'hFF, 1'b1, 8'h01, 8'h01, "R9");
    // R1, R2, R3: every word at both widths
    for (int v = 0; v < 64; v++) drive(1'b1, 8'(v), 1'b0, 8'h00, 8'h00, "R1");
    for (int v = 0; v < 256; v++) drive(1'b0, 8'(v), 1'b0, 8'h00, 8'h00, "R1");
    while (sb_q.size() > 0) @(posedge clk);
    @(posedge clk);
    finish_run();
  end

endmodule